// File: doc/BRIEF.md
# Post-Increment Load Execution Unit

This unit carries out one load whose memory address is the base register value exactly as it was read. The unit sends that address to memory and then advances the base register by an offset. A decoder supplies four things:

- the access width, as a code;
- whether a halfword or word result is sign-extended;
- which offset mode applies;
- the register indices, the base value, the index register value and the immediate field.

The unit raises one read request on a simple valid/ready memory port. It holds that request until memory takes it, then waits for the read data. Returned data is right-justified, and the unit extends it to 64 bits.

Once the data is in, the unit presents two writebacks in the same cycle. One carries the loaded value for the target register. The other carries the advanced base for the base register. If the base register index is zero, or equals the target index, the operation is refused: the unit pulses a flag, issues no memory request and writes no register. No status state of any kind is changed by these loads.

Only one operation is in flight at a time. The unit accepts a new operation in any cycle where `op_ready` is high, including the cycle in which it presents the writebacks of the previous one.

Top module: `postinc_load_unit`

## Requirements
- R1: An accepted valid operation raises `mem_req_valid` in the next cycle. `mem_addr` equals the `op_base` value given at acceptance, with nothing added. `mem_size` is 1, 2, 4 or 8 for `op_size` 0, 1, 2 or 3.
- R2: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays raised with unchanged address and size. After the request is accepted, the request is dropped in the next cycle.
- R3: With `op_ofs_mode` 0 (or 3), the base writeback is `op_base + op_index`, with the carry discarded (modulo 2^64).
- R4: With `op_ofs_mode` 1, the base writeback is `op_base` plus the 16-bit `op_imm` sign-extended to 64 bits, modulo 2^64.
- R5: With `op_ofs_mode` 2, the base writeback is `op_base` plus the sign extension of `{op_imm[13:0], 2'b00}`. Bits 15:14 of `op_imm` are ignored.
- R6: For `op_size` 0, the target writeback is `mem_rsp_data[7:0]` with bits 63:8 zero, whatever `op_signed` is.
- R7: For `op_size` 1 or 2, the low 16 or 32 bits of the read data are zero-extended when `op_signed` is 0 and sign-extended when it is 1.
- R8: For `op_size` 3, the target writeback is all 64 bits of the read data, whatever `op_signed` is.
- R9: If `op_ra_idx` is 0 or equals `op_rt_idx`, `bad_form` is high for exactly the one cycle after acceptance. No memory request and no writeback follow, and `op_ready` stays high.
- R10: `wb_rt_en` and `wb_ra_en` go high together for exactly one cycle, the cycle after the one in which `mem_rsp_valid` is seen while waiting. At that point `wb_rt_idx` and `wb_ra_idx` carry the accepted `op_rt_idx` and `op_ra_idx`.
- R11: After reset, `op_ready` is high and every request, writeback and flag output is low. `op_ready` is low from the cycle after a valid operation is accepted up to the writeback cycle, when it is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle; an offered operation is taken at this edge |
| op_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word, 3 doubleword |
| op_signed | input | 1 | Sign-extend halfword and word results |
| op_ofs_mode | input | 2 | Offset mode: 0 index register, 1 immediate, 2 scaled immediate, 3 as 0 |
| op_rt_idx | input | 5 | Target register index |
| op_ra_idx | input | 5 | Base register index |
| op_base | input | 64 | Base register value |
| op_index | input | 64 | Index register value |
| op_imm | input | 16 | Immediate field |
| mem_req_valid | output | 1 | Read request raised |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_addr | output | 64 | Read address |
| mem_size | output | 4 | Read size in bytes |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Right-justified read data |
| wb_rt_en | output | 1 | Target register write enable |
| wb_rt_idx | output | 5 | Target register index |
| wb_rt_data | output | 64 | Extended load result |
| wb_ra_en | output | 1 | Base register write enable |
| wb_ra_idx | output | 5 | Base register index |
| wb_ra_data | output | 64 | Advanced base value |
| bad_form | output | 1 | Refused register combination |

## Verification
The assertions assume that memory answers each accepted request with exactly one `mem_rsp_valid` pulse. They also assume that the pulse arrives no earlier than the cycle after acceptance and never while no request is outstanding. The stimulus keeps to this with a responder that answers only after it has seen an acceptance, after a delay of zero to two cycles. It lowers `mem_rsp_valid` as soon as the data has been taken. Operation fields are driven only together with `op_valid`, and the bench waits for `op_ready` before offering each new operation.

// File: rtl/postinc_pkg.sv
package postinc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    OFS_INDEX  = 2'd0,
    OFS_DISP   = 2'd1,
    OFS_DISP4  = 2'd2,
    OFS_INDEX2 = 2'd3
  } ofs_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fsm_e;

endpackage

// File: rtl/postinc_offset_add.sv
module postinc_offset_add
  import postinc_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  ofs_mode_e         mode,
  input  logic [XLEN-1:0]   base,
  input  logic [XLEN-1:0]   index,
  input  logic [IMM_W-1:0]  imm,
  output logic [XLEN-1:0]   next_base
);
  localparam int SCALED_W = IMM_W - 2;

  logic [XLEN-1:0] offset;

  always_comb begin
    case (mode)
      OFS_DISP:  offset = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
      OFS_DISP4: offset = {{(XLEN-IMM_W){imm[SCALED_W-1]}}, imm[SCALED_W-1:0], 2'b00};
      default:   offset = index;
    endcase
  end

  // carry out of the top bit is dropped: modulo 2^XLEN
  assign next_base = base + offset;

endmodule

// File: rtl/postinc_extend.sv
module postinc_extend
  import postinc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  acc_size_e        size,
  input  logic             sign_ext,
  input  logic [XLEN-1:0]  raw,
  output logic [XLEN-1:0]  result
);
  localparam int NARROW = 3;

  logic [XLEN-1:0] zext_c [NARROW];
  logic [XLEN-1:0] sext_c [NARROW];

  for (genvar g = 0; g < NARROW; g++) begin : g_lane
    localparam int W = 8 << g;
    assign zext_c[g] = {{(XLEN-W){1'b0}},     raw[W-1:0]};
    assign sext_c[g] = {{(XLEN-W){raw[W-1]}}, raw[W-1:0]};
  end

  always_comb begin
    case (size)
      SZ_BYTE: result = zext_c[0];
      SZ_HALF: result = sign_ext ? sext_c[1] : zext_c[1];
      SZ_WORD: result = sign_ext ? sext_c[2] : zext_c[2];
      default: result = raw;
    endcase
  end

endmodule

// File: rtl/postinc_ctrl.sv
module postinc_ctrl
  import postinc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic is_idle,
  output logic is_req,
  output logic rsp_take
);
  fsm_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (start)     state <= ST_REQ;
        ST_REQ:  if (req_ready) state <= ST_WAIT;
        ST_WAIT: if (rsp_valid) state <= ST_IDLE;
        default:                state <= ST_IDLE;
      endcase
    end
  end

  assign is_idle  = (state == ST_IDLE);
  assign is_req   = (state == ST_REQ);
  assign rsp_take = (state == ST_WAIT) && rsp_valid;

  assert_req_leaves_R2: assert property (@(posedge clk) disable iff (rst)
    (is_req && req_ready) |=> (state == ST_WAIT));

endmodule

// File: rtl/postinc_load_unit.sv
module postinc_load_unit
  import postinc_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int IDX_W  = 5,
  parameter int IMM_W  = 16,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_size,
  input  logic              op_signed,
  input  logic [1:0]        op_ofs_mode,
  input  logic [IDX_W-1:0]  op_rt_idx,
  input  logic [IDX_W-1:0]  op_ra_idx,
  input  logic [XLEN-1:0]   op_base,
  input  logic [XLEN-1:0]   op_index,
  input  logic [IMM_W-1:0]  op_imm,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_addr,
  output logic [SIZE_W-1:0] mem_size,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              wb_rt_en,
  output logic [IDX_W-1:0]  wb_rt_idx,
  output logic [XLEN-1:0]   wb_rt_data,
  output logic              wb_ra_en,
  output logic [IDX_W-1:0]  wb_ra_idx,
  output logic [XLEN-1:0]   wb_ra_data,
  output logic              bad_form
);
  logic is_idle, is_req, rsp_take;
  logic accept, form_bad, start;

  acc_size_e        size_q;
  logic             sign_q;
  logic [IDX_W-1:0] rt_q, ra_q;
  logic [XLEN-1:0]  base_q, next_base_q;
  logic [XLEN-1:0]  next_base_c, ext_c;

  assign accept   = op_valid && is_idle;
  assign form_bad = (op_ra_idx == '0) || (op_ra_idx == op_rt_idx);
  assign start    = accept && !form_bad;

  postinc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .is_idle   (is_idle),
    .is_req    (is_req),
    .rsp_take  (rsp_take)
  );

  postinc_offset_add #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ofs (
    .mode      (ofs_mode_e'(op_ofs_mode)),
    .base      (op_base),
    .index     (op_index),
    .imm       (op_imm),
    .next_base (next_base_c)
  );

  postinc_extend #(.XLEN(XLEN)) u_ext (
    .size     (size_q),
    .sign_ext (sign_q),
    .raw      (mem_rsp_data),
    .result   (ext_c)
  );

  // operation capture: the advanced base is formed here, off the writeback path
  always_ff @(posedge clk) begin
    if (rst) begin
      size_q      <= SZ_BYTE;
      sign_q      <= 1'b0;
      rt_q        <= '0;
      ra_q        <= '0;
      base_q      <= '0;
      next_base_q <= '0;
    end else if (start) begin
      size_q      <= acc_size_e'(op_size);
      sign_q      <= op_signed;
      rt_q        <= op_rt_idx;
      ra_q        <= op_ra_idx;
      base_q      <= op_base;
      next_base_q <= next_base_c;
    end
  end

  // registered writeback and flag outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_rt_en   <= 1'b0;
      wb_ra_en   <= 1'b0;
      wb_rt_idx  <= '0;
      wb_ra_idx  <= '0;
      wb_rt_data <= '0;
      wb_ra_data <= '0;
      bad_form   <= 1'b0;
    end else begin
      wb_rt_en <= rsp_take;
      wb_ra_en <= rsp_take;
      bad_form <= accept && form_bad;
      if (rsp_take) begin
        wb_rt_idx  <= rt_q;
        wb_ra_idx  <= ra_q;
        wb_rt_data <= ext_c;
        wb_ra_data <= next_base_q;
      end
    end
  end

  assign op_ready      = is_idle;
  assign mem_req_valid = is_req;
  assign mem_addr      = base_q;
  assign mem_size      = SIZE_W'(1) << size_q;

  assert_addr_is_base_R1: assert property (@(posedge clk) disable iff (rst)
    start |=> (mem_req_valid && mem_addr == $past(op_base)));

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_size)));

  assert_byte_upper_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (wb_rt_en && size_q == SZ_BYTE) |-> (wb_rt_data[XLEN-1:8] == '0));

  assert_refused_silent_R9: assert property (@(posedge clk) disable iff (rst)
    bad_form |-> (!wb_rt_en && !wb_ra_en && !mem_req_valid && op_ready));

  assert_wb_pair_R10: assert property (@(posedge clk) disable iff (rst)
    wb_rt_en |-> (wb_ra_en && wb_ra_idx != '0 && wb_ra_idx != wb_rt_idx));

  assert_wb_single_R10: assert property (@(posedge clk) disable iff (rst)
    wb_ra_en |=> !wb_ra_en);

  assert_busy_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !op_ready);

endmodule

// File: tb/test_postinc_load_unit.sv
module test_postinc_load_unit;
  localparam int CLK_P = 10;
  localparam int Q     = CLK_P / 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_size = '0;
  logic        op_signed = 1'b0;
  logic [1:0]  op_ofs_mode = '0;
  logic [4:0]  op_rt_idx = '0, op_ra_idx = '0;
  logic [63:0] op_base = '0, op_index = '0;
  logic [15:0] op_imm = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_addr;
  logic [3:0]  mem_size;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        wb_rt_en, wb_ra_en, bad_form;
  logic [4:0]  wb_rt_idx, wb_ra_idx;
  logic [63:0] wb_rt_data, wb_ra_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  postinc_load_unit i_postinc_load_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_size(op_size), .op_signed(op_signed), .op_ofs_mode(op_ofs_mode),
    .op_rt_idx(op_rt_idx), .op_ra_idx(op_ra_idx), .op_base(op_base),
    .op_index(op_index), .op_imm(op_imm), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .wb_rt_en(wb_rt_en), .wb_rt_idx(wb_rt_idx), .wb_rt_data(wb_rt_data),
    .wb_ra_en(wb_ra_en), .wb_ra_idx(wb_ra_idx), .wb_ra_data(wb_ra_data),
    .bad_form(bad_form)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] mem_val(input logic [63:0] a);
    return (a * 64'h9E37_79B9_7F4A_7C15) ^ 64'h8180_7F01_F00F_8877;
  endfunction

  function automatic logic [63:0] ref_extend(input int sz, input bit sg, input logic [63:0] d);
    logic signed [63:0] s;
    case (sz)
      0: return 64'(d[7:0]);
      1: begin s = $signed(d[15:0]); return sg ? s : 64'(d[15:0]); end
      2: begin s = $signed(d[31:0]); return sg ? s : 64'(d[31:0]); end
      default: return d;
    endcase
  endfunction

  function automatic logic [63:0] ref_next(input int fm, input logic [63:0] b,
                                           input logic [63:0] ix, input logic [15:0] im);
    logic signed [63:0] s;
    logic [15:0] scaled;
    case (fm)
      1: begin s = $signed(im); return b + s; end
      2: begin scaled = {im[13:0], 2'b00}; s = $signed(scaled); return b + s; end
      default: return b + ix;
    endcase
  endfunction

  // behavioural model state
  bit m_ready = 1, m_reqv = 0, m_wait = 0, m_wb = 0, m_bad = 0;
  logic [63:0] m_addr, m_next, m_rtdata;
  int m_sz, m_fm;
  bit m_sg;
  logic [4:0] m_rt, m_ra;
  bit pend = 0;
  int dly = 0;
  int cyc = 0;
  logic [63:0] rsp_addr;

  initial begin
    forever begin
      bit e_acc, e_rsp;
      string dtag, rtag;
      @(posedge clk);
      #(Q);
      e_acc = m_reqv && mem_req_ready;
      e_rsp = m_wait && mem_rsp_valid;
      if (rst) begin
        m_ready = 1; m_reqv = 0; m_wait = 0; m_wb = 0; m_bad = 0;
      end else begin
        m_wb = 0; m_bad = 0;
        if (m_ready && op_valid) begin
          if (op_ra_idx == 0 || op_ra_idx == op_rt_idx) m_bad = 1;
          else begin
            m_ready = 0; m_reqv = 1; m_addr = op_base; m_sz = op_size;
            m_sg = op_signed; m_fm = op_ofs_mode; m_rt = op_rt_idx; m_ra = op_ra_idx;
            m_next = ref_next(m_fm, op_base, op_index, op_imm);
          end
        end else if (e_acc) begin
          m_reqv = 0; m_wait = 1;
        end else if (e_rsp) begin
          m_wait = 0; m_wb = 1; m_ready = 1;
          m_rtdata = ref_extend(m_sz, m_sg, mem_rsp_data);
        end
      end
      // per-cycle comparison
      check(op_ready == m_ready, "R11 op_ready", 64'(op_ready), 64'(m_ready));
      check(mem_req_valid == m_reqv, "R2 mem_req_valid", 64'(mem_req_valid), 64'(m_reqv));
      if (m_reqv) begin
        check(mem_addr == m_addr, "R1 mem_addr", mem_addr, m_addr);
        check(mem_size == 4'(1 << m_sz), "R1 mem_size", 64'(mem_size), 64'(1 << m_sz));
      end
      check(bad_form == m_bad, "R9 bad_form", 64'(bad_form), 64'(m_bad));
      check(wb_rt_en == m_wb, "R10 wb_rt_en", 64'(wb_rt_en), 64'(m_wb));
      check(wb_ra_en == m_wb, "R10 wb_ra_en", 64'(wb_ra_en), 64'(m_wb));
      if (m_wb) begin
        check(wb_rt_idx == m_rt, "R10 wb_rt_idx", 64'(wb_rt_idx), 64'(m_rt));
        check(wb_ra_idx == m_ra, "R10 wb_ra_idx", 64'(wb_ra_idx), 64'(m_ra));
        dtag = (m_sz == 0) ? "R6 byte data" : (m_sz == 3) ? "R8 dword data" : "R7 half/word data";
        rtag = (m_fm == 1) ? "R4 disp base" : (m_fm == 2) ? "R5 scaled base" : "R3 index base";
        check(wb_rt_data == m_rtdata, dtag, wb_rt_data, m_rtdata);
        check(wb_ra_data == m_next, rtag, wb_ra_data, m_next);
      end
      // memory responder
      if (rst) begin
        pend = 0; mem_rsp_valid = 0;
      end else begin
        if (e_rsp) mem_rsp_valid = 0;
        if (e_acc) begin pend = 1; dly = cyc % 3; rsp_addr = m_addr; end
        if (pend && !mem_rsp_valid) begin
          if (dly == 0) begin
            mem_rsp_valid = 1; mem_rsp_data = mem_val(rsp_addr); pend = 0;
          end else dly--;
        end
      end
      mem_req_ready = ((cyc * 7) % 5) != 0;
      cyc++;
    end
  end

  task automatic run_op(input logic [1:0] sz, input bit sg, input logic [1:0] fm,
                        input logic [4:0] rt, input logic [4:0] ra,
                        input logic [63:0] b, input logic [63:0] ix, input logic [15:0] im);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_valid = 1; op_size = sz; op_signed = sg; op_ofs_mode = fm;
    op_rt_idx = rt; op_ra_idx = ra; op_base = b; op_index = ix; op_imm = im;
    @(negedge clk);
    op_valid = 0;
  endtask

  initial begin
    logic [63:0] seed;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check(op_ready == 1'b1, "R11 reset op_ready", 64'(op_ready), 64'd1);
    check(!mem_req_valid && !wb_rt_en && !wb_ra_en && !bad_form, "R11 reset outputs",
          {60'd0, mem_req_valid, wb_rt_en, wb_ra_en, bad_form}, 64'd0);
    run_op(2'd0, 1'b0, 2'd0, 5'd3, 5'd4, 64'h1000, 64'h10, 16'h0);          // R6 R3
    run_op(2'd0, 1'b1, 2'd1, 5'd5, 5'd6, 64'h2001, 64'h0, 16'hFFF8);        // R6 signed ignored, R4 negative
    run_op(2'd1, 1'b0, 2'd1, 5'd7, 5'd8, 64'h3002, 64'h0, 16'h0040);        // R7 zero half
    run_op(2'd1, 1'b1, 2'd2, 5'd9, 5'd10, 64'h3004, 64'h0, 16'hC003);       // R7 signed half, R5 top bits ignored
    run_op(2'd2, 1'b0, 2'd2, 5'd11, 5'd12, 64'h4008, 64'h0, 16'h2000);      // R7 zero word, R5 negative
    run_op(2'd2, 1'b1, 2'd0, 5'd13, 5'd14, 64'h500C, 64'hFFFF_FFFF_FFFF_FFF0, 16'h0); // R7 signed word
    run_op(2'd3, 1'b1, 2'd3, 5'd15, 5'd16, 64'hFFFF_FFFF_FFFF_FF00, 64'h200, 16'h0);  // R8, R3 wrap
    run_op(2'd3, 1'b0, 2'd1, 5'd17, 5'd18, 64'h7FFF_FFFF_FFFF_FFF8, 64'h0, 16'h7FFF); // R8, R4 positive
    run_op(2'd2, 1'b0, 2'd0, 5'd1, 5'd0, 64'h8000, 64'h8, 16'h0);           // R9 base index zero
    run_op(2'd1, 1'b0, 2'd0, 5'd20, 5'd20, 64'h9000, 64'h8, 16'h0);         // R9 same index
    run_op(2'd0, 1'b0, 2'd0, 5'd0, 5'd21, 64'hA000, 64'h1, 16'h0);          // target 0 is allowed
    seed = 64'h1234_5678_9ABC_DEF1;
    for (int i = 0; i < 60; i++) begin
      seed = seed * 64'h5851_F42D_4C95_7F2D + 64'h1405_7B7E_F767_814F;
      run_op(seed[1:0], seed[2], seed[4:3], seed[9:5], (i % 9 == 0) ? seed[9:5] : seed[14:10],
             {seed[63:16], seed[15:0] ^ 16'hA5A5}, {seed[31:0], seed[63:32]}, seed[47:32]);
    end
    repeat (20) @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule